// File: doc/BRIEF.md
# Double-Buffered Serial Frame Transmitter

This block turns bytes into asynchronous serial frames on a single output line. A one-entry holding buffer sits in front of the shift register. Software can therefore queue the next byte while the current frame is still going out, and consecutive frames leave without any idle gap between them. The frame shape is set by configuration inputs: 5 to 8 data bits, optional even or odd parity, and one or two stop bits. A baud-tick input, pulsed once per bit period by an external divider, sets the bit timing.

A completion flag reports that everything queued has been sent. It has a gated interrupt request. A caller running a half-duplex link uses it to know when it can turn the line around. Clearing the enable does not cut off traffic. The block finishes both the frame in progress and the queued byte, and only then stops driving the line.

The sequencer has these states. ST_IDLE holds the line high. ST_START sends the low start bit. ST_DATA sends the data bits, least significant first. ST_PARITY sends the optional parity bit. ST_STOP1 and ST_STOP2 send the high stop bits. The transitions are:
- idle→start: on a tick, when the buffer holds data and the block is enabled.
- start→data: on the next tick.
- data→parity or data→stop1: after the last data bit, depending on the parity enable.
- parity→stop1.
- stop1→stop2: when two stop bits are selected.
- Frame end: from the final stop bit, the sequencer goes to start if the buffer holds data, and to idle if it does not.

Top module: `dbuf_uart_tx`

## Requirements
- R1: The line idles high. A frame is one low start bit, then N data bits least significant bit first, where N = 5 + size_code (codes 0..3 give 5..8 bits). Each bit lasts one baud-tick period. The line changes only in the clock cycle after a cycle in which baud_tick is high.
- R2: When par_en is 1, one parity bit follows the last data bit and comes before the first stop bit. Its value is the XOR of the N active data bits, inverted when par_odd is 1.
- R3: A frame ends with one high stop bit, or with two when two_stop is 1.
- R4: wr_ready is high exactly when the holding buffer is empty. A byte is taken when wr_valid and wr_ready are both high at a clock edge, and wr_ready is low in the following cycle.
- R5: If the buffer holds a byte when the final stop bit ends, the next start bit begins immediately. Start bits of back-to-back frames are exactly (frame length × tick period) clocks apart.
- R6: txc_flag sets only when a frame ends and the holding buffer is empty. It stays low between back-to-back frames.
- R7: txc_flag clears in the cycle after either irq_ack or txc_clear is high. Otherwise it holds its value until the next set event.
- R8: irq is high exactly when txc_flag, irq_en and global_ie are all high.
- R9: When tx_enable is cleared, tx_oe stays high until both the shift register and the buffer are empty. It falls one cycle after the final completion flag sets.
- R10: While tx_oe is low, tx_out is high and no frame starts. A byte written while disabled waits in the buffer, and it is sent once tx_enable is raised.
- R11: After reset, wr_ready is 1, txc_flag, irq and tx_oe are 0, and tx_out is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| tx_enable | input | 1 | Transmitter enable request |
| size_code | input | SIZE_W | Data bits minus five |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | Odd parity when 1, even when 0 |
| two_stop | input | 1 | Two stop bits when 1 |
| wr_valid | input | 1 | Write request |
| wr_data | input | DATA_W | Byte to send |
| wr_ready | output | 1 | Holding buffer empty |
| txc_flag | output | 1 | All queued data sent |
| txc_clear | input | 1 | Write-one clear of txc_flag |
| irq_en | input | 1 | Local interrupt enable |
| global_ie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge, clears txc_flag |
| irq | output | 1 | Completion interrupt request |
| tx_out | output | 1 | Serial line |
| tx_oe | output | 1 | Line drive enable |

## Verification
A wrong sequencer state shows up on tx_out within one tick period as a misplaced start bit, parity bit or stop bit. The frame decoder reports it at the middle of that bit. A wrong bit counter or size decode shifts every later bit, so the data compare fails on the same frame. A wrong buffer state shows up in the same cycle as a wrong wr_ready, or one frame later as a lost or repeated byte, or as a gap between queued frames. A wrong enable or flag state shows up in the cycle it occurs, as tx_oe dropping early, txc_flag rising while data is still queued, or irq ignoring its gates.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2
    } tx_state_e;

    localparam int unsigned MIN_BITS = 5;
endpackage

// File: rtl/tx_hold_buf.sv
module tx_hold_buf #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (push) begin
            full <= 1'b1;
            data <= push_data;
        end else if (pop) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/tx_frame_fsm.sv
module tx_frame_fsm
    import uart_tx_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned SIZE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              run,
    input  logic [SIZE_W-1:0] size_code,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic              buf_full,
    input  logic [DATA_W-1:0] buf_data,
    output logic              pop,
    output logic              frame_done,
    output logic              idle,
    output logic              line
);
    localparam int unsigned CNT_W = $clog2(DATA_W);

    tx_state_e         state, nxt;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] mask;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  last;
    logic              par_bit;
    logic              load_ok;

    assign last    = CNT_W'(MIN_BITS - 1) + CNT_W'(size_code);
    assign load_ok = buf_full && run;

    always_comb begin
        for (int i = 0; i < int'(DATA_W); i++) begin
            mask[i] = (i <= int'(last));
        end
    end

    // next state, load and frame-end strobes
    always_comb begin
        nxt        = state;
        pop        = 1'b0;
        frame_done = 1'b0;
        if (baud_tick) begin
            unique case (state)
                ST_IDLE: begin
                    if (load_ok) begin
                        nxt = ST_START;
                        pop = 1'b1;
                    end
                end
                ST_START:  nxt = ST_DATA;
                ST_DATA: begin
                    if (cnt == last) nxt = par_en ? ST_PARITY : ST_STOP1;
                end
                ST_PARITY: nxt = ST_STOP1;
                ST_STOP1, ST_STOP2: begin
                    if (state == ST_STOP1 && two_stop) begin
                        nxt = ST_STOP2;
                    end else begin
                        frame_done = 1'b1;
                        nxt        = load_ok ? ST_START : ST_IDLE;
                        pop        = load_ok;
                    end
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            cnt     <= '0;
            par_bit <= 1'b0;
        end else if (pop) begin
            shreg   <= buf_data & mask;
            cnt     <= '0;
            par_bit <= (^(buf_data & mask)) ^ par_odd;
        end else if (baud_tick && state == ST_DATA) begin
            shreg <= shreg >> 1;
            cnt   <= cnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        idle = (state == ST_IDLE);
        unique case (state)
            ST_START:  line = 1'b0;
            ST_DATA:   line = shreg[0];
            ST_PARITY: line = par_bit;
            default:   line = 1'b1;
        endcase
    end
endmodule

// File: rtl/tx_done_flag.sv
module tx_done_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr_sw,
    input  logic ack,
    input  logic irq_en,
    input  logic global_ie,
    output logic flag,
    output logic irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              flag <= 1'b0;
        else if (set)            flag <= 1'b1;
        else if (clr_sw || ack)  flag <= 1'b0;
    end

    assign irq = flag && irq_en && global_ie;
endmodule

// File: rtl/dbuf_uart_tx.sv
module dbuf_uart_tx #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned SIZE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              tx_enable,
    input  logic [SIZE_W-1:0] size_code,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    output logic              txc_flag,
    input  logic              txc_clear,
    input  logic              irq_en,
    input  logic              global_ie,
    input  logic              irq_ack,
    output logic              irq,
    output logic              tx_out,
    output logic              tx_oe
);
    logic              buf_full;
    logic [DATA_W-1:0] buf_data;
    logic              pop;
    logic              frame_done;
    logic              fsm_idle;
    logic              active;

    assign wr_ready = !buf_full;
    assign tx_oe    = active;

    // enable takes effect at once, release waits for empty buffer and idle sequencer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      active <= 1'b0;
        else if (tx_enable)              active <= 1'b1;
        else if (fsm_idle && !buf_full)  active <= 1'b0;
    end

    tx_hold_buf #(.DATA_W(DATA_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_valid && !buf_full),
        .push_data (wr_data),
        .pop       (pop),
        .full      (buf_full),
        .data      (buf_data)
    );

    tx_frame_fsm #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .run        (active),
        .size_code  (size_code),
        .par_en     (par_en),
        .par_odd    (par_odd),
        .two_stop   (two_stop),
        .buf_full   (buf_full),
        .buf_data   (buf_data),
        .pop        (pop),
        .frame_done (frame_done),
        .idle       (fsm_idle),
        .line       (tx_out)
    );

    tx_done_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .set       (frame_done && !buf_full),
        .clr_sw    (txc_clear),
        .ack       (irq_ack),
        .irq_en    (irq_en),
        .global_ie (global_ie),
        .flag      (txc_flag),
        .irq       (irq)
    );
endmodule

// File: rtl/dbuf_uart_tx_chk.sv
module dbuf_uart_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic baud_tick,
    input logic wr_valid,
    input logic wr_ready,
    input logic txc_flag,
    input logic txc_clear,
    input logic irq_ack,
    input logic global_ie,
    input logic irq,
    input logic tx_out,
    input logic tx_oe
);
    AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(tx_out)); // R1

    AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_ready |=> !wr_ready); // R4

    AST_FLAG_SET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txc_flag) |-> wr_ready); // R6

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack || txc_clear) && !baud_tick |=> !txc_flag); // R7

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick && !irq_ack && !txc_clear |=> $stable(txc_flag)); // R7

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> txc_flag && global_ie); // R8

    AST_DISABLE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        tx_oe && !wr_ready |=> tx_oe); // R9

    AST_RELEASED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_oe |-> tx_out); // R10
endmodule

bind dbuf_uart_tx dbuf_uart_tx_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .txc_flag  (txc_flag),
    .txc_clear (txc_clear),
    .irq_ack   (irq_ack),
    .global_ie (global_ie),
    .irq       (irq),
    .tx_out    (tx_out),
    .tx_oe     (tx_oe)
);

// File: tb/test_dbuf_uart_tx.sv
module test_dbuf_uart_tx;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       tx_enable = 1'b0;
    logic [1:0] size_code = 2'd3;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       two_stop = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_ready;
    logic       txc_flag;
    logic       txc_clear = 1'b0;
    logic       irq_en = 1'b0;
    logic       global_ie = 1'b0;
    logic       irq_ack = 1'b0;
    logic       irq;
    logic       tx_out;
    logic       tx_oe;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int mon_frames = 0;
    int start_prev = 0;
    int start_last = 0;
    logic [7:0] expq[$];

    dbuf_uart_tx i_dbuf_uart_tx (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_enable(tx_enable),
        .size_code(size_code), .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready), .txc_flag(txc_flag),
        .txc_clear(txc_clear), .irq_en(irq_en), .global_ie(global_ie), .irq_ack(irq_ack),
        .irq(irq), .tx_out(tx_out), .tx_oe(tx_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial forever begin
        @(negedge clk);
        baud_tick = ((cyc % TICK_DIV) == TICK_DIV - 1);
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int nbits(input logic [1:0] code);
        return 5 + int'(code);
    endfunction

    function automatic logic exp_parity(input logic [7:0] d, input logic [1:0] code, input logic odd);
        logic p = odd;
        for (int i = 0; i < nbits(code); i++) p ^= d[i];
        return p;
    endfunction

    function automatic logic [7:0] exp_mask(input logic [7:0] d, input logic [1:0] code);
        logic [7:0] m = 8'h00;
        for (int i = 0; i < nbits(code); i++) m[i] = d[i];
        return m;
    endfunction

    // frame decoder: samples the middle of every bit
    initial forever begin
        @(negedge clk);
        if (rst_n && tx_oe && tx_out == 1'b0) begin
            logic [7:0] got;
            logic [7:0] want;
            logic       pbit;
            start_prev = start_last;
            start_last = cyc;
            got = 8'h00;
            repeat (2) @(negedge clk);
            chk(tx_out == 1'b0, "R1 start bit", tx_out, 0);
            for (int i = 0; i < nbits(size_code); i++) begin
                repeat (TICK_DIV) @(negedge clk);
                got[i] = tx_out;
            end
            if (par_en) begin
                repeat (TICK_DIV) @(negedge clk);
                pbit = tx_out;
            end else begin
                pbit = 1'b0;
            end
            repeat (TICK_DIV) @(negedge clk);
            chk(tx_out == 1'b1, "R3 stop bit 1", tx_out, 1);
            if (two_stop) begin
                repeat (TICK_DIV) @(negedge clk);
                chk(tx_out == 1'b1, "R3 stop bit 2", tx_out, 1);
            end
            if (expq.size() == 0) begin
                chk(1'b0, "R1 unexpected frame", got, 0);
            end else begin
                want = expq.pop_front();
                chk(got == exp_mask(want, size_code), "R1 data bits", got, exp_mask(want, size_code));
                if (par_en)
                    chk(pbit == exp_parity(want, size_code, par_odd), "R2 parity bit",
                        pbit, exp_parity(want, size_code, par_odd));
            end
            mon_frames++;
        end
    end

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        expq.push_back(d);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_flag(input string req);
        int n = 0;
        @(negedge clk);
        while (!txc_flag && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(txc_flag == 1'b1, req, txc_flag, 1);
    endtask

    task automatic clear_flag();
        @(negedge clk);
        txc_clear = 1'b1;
        @(negedge clk);
        txc_clear = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        chk(1'b0, "watchdog", cyc, WATCHDOG);
        finish_run();
    end

    initial begin
        int frames0;
        logic bad;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(wr_ready == 1'b1, "R11 wr_ready", wr_ready, 1);
        chk(txc_flag == 1'b0, "R11 txc_flag", txc_flag, 0);
        chk(irq == 1'b0, "R11 irq", irq, 0);
        chk(tx_oe == 1'b0, "R11 tx_oe", tx_oe, 0);
        chk(tx_out == 1'b1, "R11 tx_out", tx_out, 1);

        // R4, R5, R6: back-to-back 8N1
        size_code = 2'd3; par_en = 1'b0; two_stop = 1'b0;
        tx_enable = 1'b1;
        write_byte(8'hA5);
        chk(wr_ready == 1'b0, "R4 ready low after accept", wr_ready, 0);
        write_byte(8'h3C);
        while (mon_frames < 1) @(negedge clk);
        chk(txc_flag == 1'b0, "R6 flag low between queued frames", txc_flag, 0);
        wait_flag("R6 flag after last frame");
        chk(mon_frames == 2, "R5 both frames seen", mon_frames, 2);
        chk(start_last - start_prev == 10 * TICK_DIV, "R5 back-to-back spacing",
            start_last - start_prev, 10 * TICK_DIV);

        // R8 gating and R7 clear by acknowledge
        @(negedge clk);
        chk(irq == 1'b0, "R8 irq off, enables low", irq, 0);
        irq_en = 1'b1;
        @(negedge clk);
        chk(irq == 1'b0, "R8 irq off, global low", irq, 0);
        global_ie = 1'b1;
        @(negedge clk);
        chk(irq == 1'b1, "R8 irq on", irq, 1);
        chk(txc_flag == 1'b1, "R7 flag held", txc_flag, 1);
        while (baud_tick) @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        chk(txc_flag == 1'b0, "R7 cleared by ack", txc_flag, 0);
        chk(irq == 1'b0, "R8 irq drops with flag", irq, 0);

        // R7 clear by write-one after a single 5E1 frame
        size_code = 2'd0; par_en = 1'b1; par_odd = 1'b0;
        write_byte(8'hF3);
        wait_flag("R6 flag after 5E1 frame");
        while (baud_tick) @(negedge clk);
        clear_flag();
        chk(txc_flag == 1'b0, "R7 cleared by write-one", txc_flag, 0);

        // R9 disable waits for queued data
        size_code = 2'd2; par_en = 1'b1; par_odd = 1'b1; two_stop = 1'b1;
        write_byte(8'h5A);
        write_byte(8'h81);
        tx_enable = 1'b0;
        bad = 1'b0;
        @(negedge clk);
        while (!txc_flag) begin
            if (!tx_oe) bad = 1'b1;
            @(negedge clk);
        end
        chk(!bad, "R9 drive held while data pending", bad, 0);
        chk(tx_oe == 1'b1, "R9 drive held at flag set", tx_oe, 1);
        @(negedge clk);
        chk(tx_oe == 1'b0, "R9 drive released after flag", tx_oe, 0);
        chk(expq.size() == 0, "R9 queued frame sent", expq.size(), 0);
        clear_flag();

        // R10 write while disabled waits
        size_code = 2'd3; par_en = 1'b0; two_stop = 1'b0;
        frames0 = mon_frames;
        write_byte(8'hC7);
        bad = 1'b0;
        repeat (20 * TICK_DIV) begin
            @(negedge clk);
            if (tx_out != 1'b1 || tx_oe != 1'b0 || wr_ready != 1'b0) bad = 1'b1;
        end
        chk(!bad, "R10 idle high and buffered while disabled", bad, 0);
        chk(mon_frames == frames0, "R10 no frame while disabled", mon_frames, frames0);
        tx_enable = 1'b1;
        wait_flag("R10 frame after enable");
        chk(mon_frames == frames0 + 1, "R10 held byte sent", mon_frames, frames0 + 1);
        clear_flag();

        // R1, R2, R3 random formats
        for (int b = 0; b < 12; b++) begin
            size_code = 2'($urandom_range(0, 3));
            par_en    = 1'($urandom_range(0, 1));
            par_odd   = 1'($urandom_range(0, 1));
            two_stop  = 1'($urandom_range(0, 1));
            for (int k = 0; k < 3; k++) begin
                write_byte(8'($urandom));
                repeat ($urandom_range(0, 12)) @(negedge clk);
            end
            wait_flag("R6 flag after random batch");
            while (baud_tick) @(negedge clk);
            clear_flag();
        end
        repeat (4 * TICK_DIV) @(negedge clk);
        chk(expq.size() == 0, "R1 all bytes framed", expq.size(), 0);
        finish_run();
    end
endmodule